// File: doc/BRIEF.md
# Single-Step Trace Trap Controller

This block decides when an instruction-execution core must take a single-step trace trap, and which return address goes with it. The status register's trace-enable bit is sampled into a pending flag each time a real instruction starts. When that instruction finishes with the flag still set, the block asks the core for a trace trap. Other traps and interrupts always win. If one of them is entered at the end of a traced instruction, the trace trap waits until every nested service has returned. Only then is the request raised, so each traced instruction yields at most one trace trap.

Three special cases are handled:
- A privileged status write can clear the trace bits mid-instruction, which cancels the trap.
- A WAIT instruction holds the trace trap back until an interrupt has been serviced and has returned.
- A long looping instruction aborted by an interrupt is reported with its own address, not the next one, so that a later step resumes it.

The core drives one-cycle strobes for instruction start, instruction end, WAIT completion, exception entry and exception return. It acknowledges the trace trap with a strobe once it vectors to the trace handler.

Top module: `trc_ctrl`

## Requirements
- R1: After synchronous reset, pend_o, trc_req_o and ret_addr_o are all 0.
- R2: An accepted instr_begin_i loads trace_en_i into pend_o on the next cycle. When undef_i is high with instr_begin_i, pend_o keeps its previous value.
- R3: An instr_end_i with pend_o set and no service active raises trc_req_o on the next cycle, with ret_addr_o equal to next_pc_i as sampled at the end strobe. The request and the address hold until trap_ack_i. After the acknowledge, both trc_req_o and pend_o read 0 on the following cycle.
- R4: A psr_clr_i strobe inside an instruction clears pend_o, and no trace trap follows at that instruction's end.
- R5: The trace trap has the lowest priority.
  - An exc_req_i in the same cycle as the traced instr_end_i defers the request until the nesting depth returns to zero through exc_ret_i.
  - An exc_req_i while trc_req_o is high withdraws the request on the next cycle, and it is re-raised after the return.
- R6: Exception depth counts up on exc_req_i and down on exc_ret_i, saturating at 2^NEST_W-1. While any service is active, the instruction strobes leave pend_o unchanged.
- R7: A wait_end_i with pend_o set raises no trace trap until at least one exc_req_i has been entered and the depth has returned to zero. ret_addr_o then equals next_pc_i as sampled at wait_end_i.
- R8: An exc_req_i with abort_i high inside a traced instruction ends that instruction. The trace trap is raised after the return, with ret_addr_o equal to cur_pc_i as sampled at the abort.
- R9: After a trace trap is acknowledged, no further trace request appears until a new instruction has started with tracing enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_begin_i | input | 1 | Start of an instruction |
| undef_i | input | 1 | Qualifies instr_begin_i as entry into an undefined-instruction trap |
| instr_end_i | input | 1 | End of an instruction |
| wait_end_i | input | 1 | A WAIT instruction has completed and the core is idling |
| trace_en_i | input | 1 | Trace-enable bit of the status register |
| psr_clr_i | input | 1 | Privileged status write that clears the trace bits |
| exc_req_i | input | 1 | Entry into a trap or interrupt service |
| abort_i | input | 1 | Qualifies exc_req_i as aborting a long looping instruction |
| exc_ret_i | input | 1 | Return from a trap or interrupt service |
| trap_ack_i | input | 1 | Core has taken the trace trap |
| next_pc_i | input | ADDR_W | Address of the next instruction |
| cur_pc_i | input | ADDR_W | Address of the executing instruction |
| pend_o | output | 1 | Trace pending flag |
| trc_req_o | output | 1 | Trace trap request |
| ret_addr_o | output | ADDR_W | Return address for the trace trap |

## Verification
The bench builds the block with ADDR_W = 16 and NEST_W = 2, so the exception depth saturates at three. A fourth nested entry therefore brings the saturation boundary of R6 within a few cycles. The 16-bit addresses keep distinct next and restart addresses easy to tell apart. This makes the choice between cur_pc_i and next_pc_i for aborted and ordinary instructions directly visible at ret_addr_o.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef struct packed {
        logic pend;      // trace pending flag
        logic in_instr;  // an instruction is executing
        logic owed;      // a trace trap is owed but deferred
        logic need_svc;  // WAIT case: an interrupt must be serviced first
        logic req;       // trace trap request towards the core
    } trc_state_t;

    localparam trc_state_t TRC_RESET = '{default: 1'b0};

endpackage

// File: rtl/trc_nest.sv
module trc_nest #(
    parameter int NEST_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic enter_i,
    input  logic leave_i,
    output logic idle_q_o,
    output logic idle_d_o
);
    localparam logic [NEST_W-1:0] DEPTH_MAX = {NEST_W{1'b1}};
    localparam logic [NEST_W-1:0] DEPTH_ONE = {{(NEST_W-1){1'b0}}, 1'b1};

    logic [NEST_W-1:0] depth_d, depth_q;
    logic              up, down;

    always_comb begin
        up      = enter_i && (depth_q != DEPTH_MAX);
        down    = leave_i && (depth_q != '0);
        depth_d = depth_q;
        if (up && !down) begin
            depth_d = depth_q + DEPTH_ONE;
        end else if (down && !up) begin
            depth_d = depth_q - DEPTH_ONE;
        end
        idle_d_o = (depth_d == '0);
        idle_q_o = (depth_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else begin
            depth_q <= depth_d;
        end
    end

endmodule

// File: rtl/trc_addr.sv
module trc_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic              restart_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [ADDR_W-1:0] cur_pc_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (capture_i) begin
            addr_d = restart_i ? cur_pc_i : next_pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/trc_seq.sv
module trc_seq
    import trc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic instr_begin_i,
    input  logic undef_i,
    input  logic instr_end_i,
    input  logic wait_end_i,
    input  logic trace_en_i,
    input  logic psr_clr_i,
    input  logic exc_req_i,
    input  logic abort_i,
    input  logic trap_ack_i,
    input  logic nest_idle_q_i,
    input  logic nest_idle_d_i,
    output logic pend_o,
    output logic req_o,
    output logic capture_o,
    output logic restart_o
);
    trc_state_t st_d, st_q;

    logic busy, begin_ev, end_ev, wend_ev, abort_ev, clr_ev;
    logic pend_eff, took, capture, owed_pre, fire;

    always_comb begin
        busy     = !nest_idle_q_i || st_q.owed || st_q.req;
        begin_ev = instr_begin_i && !busy;
        end_ev   = instr_end_i && !busy && st_q.in_instr;
        wend_ev  = wait_end_i && !busy && st_q.in_instr;
        abort_ev = exc_req_i && abort_i && !busy && st_q.in_instr;
        clr_ev   = psr_clr_i && !busy && st_q.in_instr;

        // a clearing status write lands before the end of the same instruction
        pend_eff = st_q.pend && !clr_ev;
        took     = st_q.req && trap_ack_i;
        capture  = pend_eff && (end_ev || wend_ev || abort_ev);

        st_d      = st_q;
        st_d.pend = pend_eff;
        if (begin_ev && !undef_i) begin
            st_d.pend = trace_en_i;
        end
        if (took) begin
            st_d.pend = 1'b0;
        end

        if (begin_ev) begin
            st_d.in_instr = 1'b1;
        end else if (end_ev || wend_ev || abort_ev) begin
            st_d.in_instr = 1'b0;
        end

        st_d.need_svc = (st_q.need_svc || (wend_ev && pend_eff)) && !exc_req_i;

        // a higher-priority entry pushes an unacknowledged request back to owed
        owed_pre  = st_q.owed || capture || (st_q.req && exc_req_i && !trap_ack_i);
        fire      = owed_pre && nest_idle_d_i && !st_d.need_svc;
        st_d.owed = owed_pre && !fire;
        st_d.req  = (st_q.req && !trap_ack_i && !exc_req_i) || fire;

        capture_o = capture;
        restart_o = abort_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= TRC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign req_o  = st_q.req;

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
    parameter int ADDR_W = 32,
    parameter int NEST_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_begin_i,
    input  logic              undef_i,
    input  logic              instr_end_i,
    input  logic              wait_end_i,
    input  logic              trace_en_i,
    input  logic              psr_clr_i,
    input  logic              exc_req_i,
    input  logic              abort_i,
    input  logic              exc_ret_i,
    input  logic              trap_ack_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [ADDR_W-1:0] cur_pc_i,
    output logic              pend_o,
    output logic              trc_req_o,
    output logic [ADDR_W-1:0] ret_addr_o
);
    logic nest_idle_q, nest_idle_d, capture, restart;

    trc_nest #(.NEST_W(NEST_W)) u_nest (
        .clk      (clk),
        .rst      (rst),
        .enter_i  (exc_req_i),
        .leave_i  (exc_ret_i),
        .idle_q_o (nest_idle_q),
        .idle_d_o (nest_idle_d)
    );

    trc_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .instr_begin_i (instr_begin_i),
        .undef_i       (undef_i),
        .instr_end_i   (instr_end_i),
        .wait_end_i    (wait_end_i),
        .trace_en_i    (trace_en_i),
        .psr_clr_i     (psr_clr_i),
        .exc_req_i     (exc_req_i),
        .abort_i       (abort_i),
        .trap_ack_i    (trap_ack_i),
        .nest_idle_q_i (nest_idle_q),
        .nest_idle_d_i (nest_idle_d),
        .pend_o        (pend_o),
        .req_o         (trc_req_o),
        .capture_o     (capture),
        .restart_o     (restart)
    );

    trc_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .restart_i (restart),
        .next_pc_i (next_pc_i),
        .cur_pc_i  (cur_pc_i),
        .addr_o    (ret_addr_o)
    );

endmodule

// File: rtl/trc_ctrl_chk.sv
module trc_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_begin_i,
    input logic              undef_i,
    input logic              psr_clr_i,
    input logic              exc_req_i,
    input logic              trap_ack_i,
    input logic              pend_o,
    input logic              trc_req_o,
    input logic [ADDR_W-1:0] ret_addr_o
);
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
        trc_req_o && trap_ack_i |=> !trc_req_o && !pend_o);

    assert_req_holds_R3: assert property (@(posedge clk) disable iff (rst)
        trc_req_o && !trap_ack_i && !exc_req_i |=> trc_req_o && $stable(ret_addr_o));

    assert_lowest_prio_R5: assert property (@(posedge clk) disable iff (rst)
        exc_req_i |=> !trc_req_o);

    assert_undef_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        instr_begin_i && undef_i && !trap_ack_i && !psr_clr_i |=> pend_o == $past(pend_o));

    assert_one_per_instr_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(trc_req_o) |-> pend_o);

endmodule

bind trc_ctrl trc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_begin_i (instr_begin_i),
    .undef_i       (undef_i),
    .psr_clr_i     (psr_clr_i),
    .exc_req_i     (exc_req_i),
    .trap_ack_i    (trap_ack_i),
    .pend_o        (pend_o),
    .trc_req_o     (trc_req_o),
    .ret_addr_o    (ret_addr_o)
);

// File: tb/trc_ctrl_test.sv
`timescale 1ns/1ps
module trc_ctrl_test;
    localparam int AW = 16;
    localparam int NW = 2;
    localparam int NMAX = (1 << NW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic instr_begin_i = 0, undef_i = 0, instr_end_i = 0, wait_end_i = 0;
    logic trace_en_i = 0, psr_clr_i = 0, exc_req_i = 0, abort_i = 0;
    logic exc_ret_i = 0, trap_ack_i = 0;
    logic [AW-1:0] next_pc_i = '0, cur_pc_i = '0;
    logic pend_o, trc_req_o;
    logic [AW-1:0] ret_addr_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int m_nest = 0;
    bit m_pend = 0, m_inins = 0, m_owed = 0, m_wait = 0, m_req = 0;
    logic [AW-1:0] m_addr = '0;

    always #2 clk = ~clk;

    trc_ctrl #(.ADDR_W(AW), .NEST_W(NW)) uut (
        .clk(clk), .rst(rst), .instr_begin_i(instr_begin_i), .undef_i(undef_i),
        .instr_end_i(instr_end_i), .wait_end_i(wait_end_i), .trace_en_i(trace_en_i),
        .psr_clr_i(psr_clr_i), .exc_req_i(exc_req_i), .abort_i(abort_i),
        .exc_ret_i(exc_ret_i), .trap_ack_i(trap_ack_i), .next_pc_i(next_pc_i),
        .cur_pc_i(cur_pc_i), .pend_o(pend_o), .trc_req_o(trc_req_o),
        .ret_addr_o(ret_addr_o)
    );

    task automatic model();
        bit in_svc, p, ended, owe_now;
        if (rst) begin
            m_nest = 0; m_pend = 0; m_inins = 0; m_owed = 0; m_wait = 0;
            m_req = 0; m_addr = '0;
            return;
        end
        in_svc = (m_nest > 0) || m_owed || m_req;
        p = m_pend;
        if (!in_svc && m_inins && psr_clr_i) p = 0;
        owe_now = 0;
        if (!in_svc && m_inins && (instr_end_i || wait_end_i || (exc_req_i && abort_i))) begin
            ended = 1;
            if (p) begin
                owe_now = 1;
                m_addr = (exc_req_i && abort_i) ? cur_pc_i : next_pc_i;
                if (wait_end_i && !exc_req_i) m_wait = 1;
            end
            m_inins = 0;
        end else begin
            ended = 0;
        end
        if (!in_svc && instr_begin_i) begin
            m_inins = 1;
            if (!undef_i) p = trace_en_i;
        end
        if (exc_req_i) m_wait = 0;
        if (m_req && trap_ack_i) begin
            p = 0;
            m_req = 0;
        end else if (m_req && exc_req_i) begin
            m_req = 0;
            owe_now = 1;
        end
        if (exc_req_i && !exc_ret_i && m_nest < NMAX) m_nest++;
        else if (exc_ret_i && !exc_req_i && m_nest > 0) m_nest--;
        else if (exc_ret_i && exc_req_i && m_nest == 0) m_nest = 1;
        if (owe_now) m_owed = 1;
        if (m_owed && m_nest == 0 && !m_wait) begin
            m_owed = 0;
            m_req = 1;
        end
        m_pend = p;
        if (ended) ended = 0;
    endtask

    task automatic compare();
        tests++;
        if (pend_o !== m_pend || trc_req_o !== m_req || ret_addr_o !== m_addr) begin
            fails++;
            $display("FAIL %s cycle model: pend/req/addr act %b/%b/%h exp %b/%b/%h",
                     tag, pend_o, trc_req_o, ret_addr_o, m_pend, m_req, m_addr);
        end
    endtask

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act %h exp %h", t, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model();
        #1;
        compare();
        instr_begin_i = 0; undef_i = 0; instr_end_i = 0; wait_end_i = 0;
        psr_clr_i = 0; exc_req_i = 0; abort_i = 0; exc_ret_i = 0; trap_ack_i = 0;
    endtask

    initial begin
        repeat (3) step();
        rst = 0;
        tag = "R1";
        chk("R1 pend", 32'(pend_o), 0);
        chk("R1 req", 32'(trc_req_o), 0);
        chk("R1 addr", 32'(ret_addr_o), 0);

        // basic trace trap
        tag = "R3";
        trace_en_i = 1; instr_begin_i = 1; step();
        chk("R2 pend copied", 32'(pend_o), 1);
        next_pc_i = 16'h1234; instr_end_i = 1; step();
        chk("R3 req", 32'(trc_req_o), 1);
        chk("R3 addr", 32'(ret_addr_o), 32'h1234);
        step();
        chk("R3 req held", 32'(trc_req_o), 1);
        trap_ack_i = 1; step();
        chk("R3 req after ack", 32'(trc_req_o), 0);
        chk("R3 pend after ack", 32'(pend_o), 0);
        tag = "R9";
        instr_end_i = 1; step();
        chk("R9 no second trap", 32'(trc_req_o), 0);
        step();
        chk("R9 still quiet", 32'(trc_req_o), 0);

        // tracing disabled
        tag = "R2";
        trace_en_i = 0; instr_begin_i = 1; step();
        chk("R2 pend copied zero", 32'(pend_o), 0);
        instr_end_i = 1; step();
        chk("R2 no trap untraced", 32'(trc_req_o), 0);

        // undefined-instruction entry is not a start
        trace_en_i = 1; instr_begin_i = 1; step();
        trace_en_i = 0; instr_begin_i = 1; undef_i = 1; step();
        chk("R2 undef keeps pend", 32'(pend_o), 1);
        next_pc_i = 16'h1300; instr_end_i = 1; step();
        chk("R2 trap after undef", 32'(trc_req_o), 1);
        chk("R2 addr", 32'(ret_addr_o), 32'h1300);
        trap_ack_i = 1; step();

        // privileged clear
        tag = "R4";
        trace_en_i = 1; instr_begin_i = 1; step();
        psr_clr_i = 1; step();
        chk("R4 pend cleared", 32'(pend_o), 0);
        instr_end_i = 1; step();
        chk("R4 no trap", 32'(trc_req_o), 0);

        // deferral behind a trap, then withdraw and refire
        tag = "R5";
        instr_begin_i = 1; step();
        next_pc_i = 16'h2000; instr_end_i = 1; exc_req_i = 1; step();
        chk("R5 deferred", 32'(trc_req_o), 0);
        chk("R5 pend kept", 32'(pend_o), 1);
        tag = "R6";
        trace_en_i = 0; instr_begin_i = 1; step();
        chk("R6 begin in service ignored", 32'(pend_o), 1);
        instr_end_i = 1; step();
        chk("R6 end in service ignored", 32'(trc_req_o), 0);
        tag = "R5";
        exc_ret_i = 1; step();
        chk("R5 fires after return", 32'(trc_req_o), 1);
        chk("R5 addr", 32'(ret_addr_o), 32'h2000);
        exc_req_i = 1; step();
        chk("R5 withdrawn", 32'(trc_req_o), 0);
        step();
        chk("R5 still withdrawn", 32'(trc_req_o), 0);
        exc_ret_i = 1; step();
        chk("R5 refired", 32'(trc_req_o), 1);
        chk("R5 refired addr", 32'(ret_addr_o), 32'h2000);
        trap_ack_i = 1; step();
        chk("R5 pend after ack", 32'(pend_o), 0);

        // depth saturation
        tag = "R6";
        trace_en_i = 1; instr_begin_i = 1; step();
        next_pc_i = 16'h2100; instr_end_i = 1; exc_req_i = 1; step();
        for (int i = 0; i < 3; i++) begin exc_req_i = 1; step(); end
        exc_ret_i = 1; step();
        exc_ret_i = 1; step();
        chk("R6 not yet", 32'(trc_req_o), 0);
        exc_ret_i = 1; step();
        chk("R6 saturated depth fires", 32'(trc_req_o), 1);
        chk("R6 addr", 32'(ret_addr_o), 32'h2100);
        trap_ack_i = 1; step();

        // WAIT instruction
        tag = "R7";
        instr_begin_i = 1; step();
        next_pc_i = 16'h3000; wait_end_i = 1; step();
        step(); step();
        chk("R7 held during wait", 32'(trc_req_o), 0);
        chk("R7 pend", 32'(pend_o), 1);
        exc_req_i = 1; step();
        chk("R7 in service", 32'(trc_req_o), 0);
        exc_ret_i = 1; step();
        chk("R7 fires after interrupt", 32'(trc_req_o), 1);
        chk("R7 addr", 32'(ret_addr_o), 32'h3000);
        trap_ack_i = 1; step();

        // aborted looping instruction
        tag = "R8";
        cur_pc_i = 16'h4000; next_pc_i = 16'h4004;
        instr_begin_i = 1; step();
        exc_req_i = 1; abort_i = 1; step();
        chk("R8 deferred", 32'(trc_req_o), 0);
        exc_ret_i = 1; step();
        chk("R8 fires", 32'(trc_req_o), 1);
        chk("R8 restart addr", 32'(ret_addr_o), 32'h4000);
        trap_ack_i = 1; step();
        instr_begin_i = 1; step();
        instr_end_i = 1; step();
        chk("R8 resume traps", 32'(trc_req_o), 1);
        chk("R8 next addr", 32'(ret_addr_o), 32'h4004);
        trap_ack_i = 1; step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired in %s", tag);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule